// File: doc/BRIEF.md
# Effective Address Generator

This block forms a 64-bit memory address from up to three terms: a signed 32-bit displacement, a base register value and an index register value scaled by 1, 2, 4 or 8. Two enable flags choose which register terms take part, so a single datapath covers every addressing form. These forms are absolute (displacement only), register indirect, base plus offset, base plus index, and scaled index with or without a base.

A request flag marks an address-computation-only operation. For such an operation the sum is handed back as a plain data result and no memory access is signalled. For any other request the same sum is flagged as a memory address. By default the result is captured in an output register, so it appears one cycle after the request with a valid strobe. A parameter can drop the register, and the result then follows the inputs in the same cycle. Register file reads, segment handling, program-counter-relative forms and the memory access itself are handled elsewhere.

Top module: `eff_addr_gen`

## Requirements
- R1: With both the base enable and the index enable low, the result equals the sign-extended displacement.
- R2: With only the base enable high, the result is the base value plus the sign-extended displacement, so a zero displacement returns the base value unchanged.
- R3: With only the index enable high, the result is the sign-extended displacement plus the index value times the scale factor.
- R4: Scale code 2'b00, 2'b01, 2'b10 and 2'b11 multiplies the index by 1, 2, 4 and 8 respectively.
- R5: With both enables high, the result is displacement + base + index × scale.
- R6: Displacement bit 31 is copied into result bits 63:32 before the addition, so a negative displacement subtracts.
- R7: All sums wrap modulo 2^64 and no overflow is reported.
- R8: A valid request with the address-only flag set raises `res_is_data` and keeps `res_mem_req` low. A valid request with the flag clear raises `res_mem_req` and keeps `res_is_data` low. Both are low whenever `res_valid` is low.
- R9: With the default registered output, `res_valid` and the result appear on the clock edge after `req_valid` is sampled high. A cycle without `req_valid` drops `res_valid` and leaves `res_addr` unchanged.
- R10: While `rst_n` is low at a clock edge, `res_valid`, `res_is_data`, `res_mem_req` and `res_addr` are cleared to zero.
- R11: A register value whose enable is low has no effect on the result, whatever its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_disp | input | 32 | Signed displacement |
| req_base | input | 64 | Base register value |
| req_base_en | input | 1 | Base term included |
| req_index | input | 64 | Index register value |
| req_index_en | input | 1 | Index term included |
| req_scale | input | 2 | Scale code for the index (×1, ×2, ×4, ×8) |
| req_addr_only | input | 1 | Return the sum as data, with no memory access |
| res_valid | output | 1 | Result valid |
| res_addr | output | 64 | Computed address or data result |
| res_is_data | output | 1 | Result is a data value |
| res_mem_req | output | 1 | Result is an address for a memory access |

## Verification
The bench drives each enable combination in turn: no register terms, base only, index only and both. A wrong term-gating or summing path therefore shows up in exactly one mode. The index-only case is repeated with all four scale codes on the same index, so a wrong shift amount gives a visibly different sum. A negative displacement and a base near the top of the address space separate a missing sign extension from a wrong wrap. Garbage values on disabled register inputs show whether disabled terms really drop out. Requests with and without the address-only flag, followed by idle cycles, test the kind flags and the hold behaviour of the output register.

// File: rtl/eag_pkg.sv
// Package: shared widths and the scale code encoding for the address generator.
// Assumes two's complement arithmetic on all datapath vectors.
package eag_pkg;
    localparam int unsigned EAG_ADDR_W  = 64;
    localparam int unsigned EAG_DISP_W  = 32;
    localparam int unsigned EAG_SCALE_W = 2;

    // Scale factor selected by the 2-bit code; the value is the shift amount.
    typedef enum logic [EAG_SCALE_W-1:0] {
        SCALE_X1 = 2'b00,
        SCALE_X2 = 2'b01,
        SCALE_X4 = 2'b10,
        SCALE_X8 = 2'b11
    } eag_scale_e;
endpackage

// File: rtl/eag_index_scaler.sv
// Module: gates the index term by its enable and multiplies it by 2^scale.
// Assumes the scale code is a plain shift amount (0..2^SCALE_W-1).
module eag_index_scaler #(
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned SCALE_W = 2
) (
    input  logic [ADDR_W-1:0]  index_val,
    input  logic               index_en,
    input  logic [SCALE_W-1:0] scale_code,
    output logic [ADDR_W-1:0]  index_term
);
    // Shift the enabled index left by the scale code; zero when disabled.
    always_comb begin
        if (index_en) begin
            index_term = index_val << scale_code;
        end else begin
            index_term = '0;
        end
    end
endmodule

// File: rtl/eag_sum.sv
// Module: sign-extends the displacement and adds it to the gated base and the
// scaled index term. Assumes wrap-around arithmetic modulo 2^ADDR_W.
module eag_sum #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DISP_W = 32
) (
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              base_en,
    input  logic [ADDR_W-1:0] index_term,
    output logic [ADDR_W-1:0] sum
);
    localparam int unsigned EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] base_term;

    // Replicate the displacement sign bit into the upper bits.
    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end

    // Drop the base when it is not part of the address form.
    always_comb begin
        base_term = base_en ? base_val : '0;
    end

    // Three-term wrap-around sum.
    always_comb begin
        sum = disp_ext + base_term + index_term;
    end
endmodule

// File: rtl/eag_result_stage.sv
// Module: presents the sum with its valid strobe and kind flags, either
// through a register (REG_OUT=1, one cycle latency) or combinationally.
// Assumes a synchronous active-low reset.
module eag_result_stage #(
    parameter int unsigned ADDR_W  = 64,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_addr_only,
    input  logic [ADDR_W-1:0] in_sum,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_is_data,
    output logic              out_mem_req
);
    logic next_is_data;
    logic next_mem_req;

    // Classify the request as a data result or a memory address.
    always_comb begin
        next_is_data = in_valid & in_addr_only;
        next_mem_req = in_valid & ~in_addr_only;
    end

    generate
        if (REG_OUT) begin : g_reg
            // Capture a new result on a request; hold the address otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid   <= 1'b0;
                    out_addr    <= '0;
                    out_is_data <= 1'b0;
                    out_mem_req <= 1'b0;
                end else begin
                    out_valid   <= in_valid;
                    out_is_data <= next_is_data;
                    out_mem_req <= next_mem_req;
                    if (in_valid) begin
                        out_addr <= in_sum;
                    end
                end
            end
        end else begin : g_comb
            // Pass the result straight through in the request cycle.
            always_comb begin
                out_valid   = in_valid;
                out_addr    = in_sum;
                out_is_data = next_is_data;
                out_mem_req = next_mem_req;
            end
        end
    endgenerate
endmodule

// File: rtl/eff_addr_gen.sv
// Module: effective address generator top. Forms disp + base + index*scale
// with each register term optional, and flags the result as either data or a
// memory address. Assumes register values are already read.
module eff_addr_gen #(
    parameter int unsigned ADDR_W  = eag_pkg::EAG_ADDR_W,
    parameter int unsigned DISP_W  = eag_pkg::EAG_DISP_W,
    parameter int unsigned SCALE_W = eag_pkg::EAG_SCALE_W,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [DISP_W-1:0]  req_disp,
    input  logic [ADDR_W-1:0]  req_base,
    input  logic               req_base_en,
    input  logic [ADDR_W-1:0]  req_index,
    input  logic               req_index_en,
    input  logic [SCALE_W-1:0] req_scale,
    input  logic               req_addr_only,
    output logic               res_valid,
    output logic [ADDR_W-1:0]  res_addr,
    output logic               res_is_data,
    output logic               res_mem_req
);
    logic [ADDR_W-1:0] index_term;
    logic [ADDR_W-1:0] sum;

    eag_index_scaler #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_scaler (
        .index_val  (req_index),
        .index_en   (req_index_en),
        .scale_code (req_scale),
        .index_term (index_term)
    );

    eag_sum #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_sum (
        .disp       (req_disp),
        .base_val   (req_base),
        .base_en    (req_base_en),
        .index_term (index_term),
        .sum        (sum)
    );

    eag_result_stage #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (req_valid),
        .in_addr_only (req_addr_only),
        .in_sum       (sum),
        .out_valid    (res_valid),
        .out_addr     (res_addr),
        .out_is_data  (res_is_data),
        .out_mem_req  (res_mem_req)
    );
endmodule

// File: rtl/eff_addr_gen_chk.sv
// Module: assertion checker for eff_addr_gen, attached by bind below.
// Assumes the same parameters as the top it is bound to.
module eff_addr_gen_chk #(
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned DISP_W  = 32,
    parameter int unsigned SCALE_W = 2,
    parameter bit          REG_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [DISP_W-1:0]  req_disp,
    input logic [ADDR_W-1:0]  req_base,
    input logic               req_base_en,
    input logic [ADDR_W-1:0]  req_index,
    input logic               req_index_en,
    input logic [SCALE_W-1:0] req_scale,
    input logic               req_addr_only,
    input logic               res_valid,
    input logic [ADDR_W-1:0]  res_addr,
    input logic               res_is_data,
    input logic               res_mem_req
);
    localparam int unsigned EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] chk_disp;
    logic [ADDR_W-1:0] chk_full;

    // Reference sum written from the requirements, not from the datapath.
    always_comb begin
        chk_disp = {{EXT_W{req_disp[DISP_W-1]}}, req_disp};
        chk_full = chk_disp
                 + (req_base_en  ? req_base : {ADDR_W{1'b0}})
                 + (req_index_en ? (req_index << req_scale) : {ADDR_W{1'b0}});
    end

    // R8: a result is never both data and a memory address.
    assert_kind_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_is_data && res_mem_req));

    // R8: exactly one kind flag accompanies a valid result.
    assert_kind_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == (res_is_data || res_mem_req));

    generate
        if (REG_OUT) begin : g_seq
            // R1: absolute form yields the extended displacement.
            assert_absolute_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && !req_base_en && !req_index_en) |=> res_addr == $past(chk_disp));

            // R2: base with zero displacement and no index returns the base.
            assert_indirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && req_base_en && !req_index_en && req_disp == '0)
                    |=> res_addr == $past(req_base));

            // R5: general form in all modes.
            assert_full_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
                req_valid |=> res_addr == $past(chk_full));

            // R9: one cycle latency of the valid strobe.
            assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
                req_valid |=> res_valid);

            // R9: an idle cycle drops valid and holds the address.
            assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !req_valid |=> (!res_valid && $stable(res_addr)));

            // R8: address-only requests come back as data.
            assert_data_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && req_addr_only) |=> (res_is_data && !res_mem_req));

            // R10: reset clears every output on the next edge.
            assert_reset_R10: assert property (@(posedge clk)
                !rst_n |=> (!res_valid && !res_is_data && !res_mem_req && res_addr == '0));
        end else begin : g_comb
            // R5: general form, same cycle.
            assert_full_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
                req_valid |-> res_addr == chk_full);

            // R9: valid follows the request in the same cycle.
            assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
                res_valid == req_valid);
        end
    endgenerate
endmodule

bind eff_addr_gen eff_addr_gen_chk #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .SCALE_W(SCALE_W), .REG_OUT(REG_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_disp(req_disp),
    .req_base(req_base), .req_base_en(req_base_en), .req_index(req_index),
    .req_index_en(req_index_en), .req_scale(req_scale),
    .req_addr_only(req_addr_only), .res_valid(res_valid), .res_addr(res_addr),
    .res_is_data(res_is_data), .res_mem_req(res_mem_req)
);

// File: tb/sim_eff_addr_gen.sv
// Bench: directed scenarios for eff_addr_gen with the default registered output.
module sim_eff_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_disp = '0;
    logic [63:0] req_base = '0;
    logic        req_base_en = 1'b0;
    logic [63:0] req_index = '0;
    logic        req_index_en = 1'b0;
    logic [1:0]  req_scale = '0;
    logic        req_addr_only = 1'b0;
    logic        res_valid;
    logic [63:0] res_addr;
    logic        res_is_data;
    logic        res_mem_req;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    eff_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_disp(req_disp),
        .req_base(req_base), .req_base_en(req_base_en), .req_index(req_index),
        .req_index_en(req_index_en), .req_scale(req_scale),
        .req_addr_only(req_addr_only), .res_valid(res_valid), .res_addr(res_addr),
        .res_is_data(res_is_data), .res_mem_req(res_mem_req)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge; sample the registered result one cycle later.
    task automatic issue(input logic [31:0] d, input logic [63:0] b, input logic be,
                         input logic [63:0] i, input logic ie, input logic [1:0] sc,
                         input logic ao);
        @(negedge clk);
        req_valid = 1'b1; req_disp = d; req_base = b; req_base_en = be;
        req_index = i; req_index_en = ie; req_scale = sc; req_addr_only = ao;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 valid", {63'd0, res_valid}, 64'd0);
        check("R10 addr", res_addr, 64'd0);
        check("R10 kind", {62'd0, res_is_data, res_mem_req}, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_absolute();
        issue(32'h0000_1234, 64'd0, 1'b0, 64'd0, 1'b0, 2'b00, 1'b0);
        check("R1 absolute", res_addr, 64'h0000_0000_0000_1234);
        check("R9 valid", {63'd0, res_valid}, 64'd1);
        issue(32'hFFFF_FFF0, 64'd0, 1'b0, 64'd0, 1'b0, 2'b00, 1'b0);
        check("R6 negative disp", res_addr, 64'hFFFF_FFFF_FFFF_FFF0);
    endtask

    task automatic t_indirect();
        issue(32'd0, 64'h1234_5678_9ABC_DEF0, 1'b1, 64'd0, 1'b0, 2'b00, 1'b0);
        check("R2 indirect", res_addr, 64'h1234_5678_9ABC_DEF0);
        issue(32'hFFFF_FFF8, 64'h0000_0000_0000_1000, 1'b1, 64'd0, 1'b0, 2'b00, 1'b0);
        check("R2 R6 base minus 8", res_addr, 64'h0000_0000_0000_0FF8);
    endtask

    task automatic t_scaled();
        logic [63:0] exp_tab [4] = '{64'h140, 64'h240, 64'h440, 64'h840};
        for (int k = 0; k < 4; k++) begin
            issue(32'h40, 64'd0, 1'b0, 64'h100, 1'b1, k[1:0], 1'b0);
            check("R3 R4 scaled no base", res_addr, exp_tab[k]);
        end
    endtask

    task automatic t_full();
        issue(32'h10, 64'h1000, 1'b1, 64'd3, 1'b1, 2'b11, 1'b0);
        check("R5 full form", res_addr, 64'h1028);
        issue(32'd0, 64'h2000, 1'b1, 64'h30, 1'b1, 2'b00, 1'b0);
        check("R5 R4 base plus index x1", res_addr, 64'h2030);
    endtask

    task automatic t_wrap();
        issue(32'h10, 64'hFFFF_FFFF_FFFF_FFF8, 1'b1, 64'd0, 1'b0, 2'b00, 1'b0);
        check("R7 wrap", res_addr, 64'h8);
        issue(32'd0, 64'd0, 1'b0, 64'h8000_0000_0000_0001, 1'b1, 2'b01, 1'b0);
        check("R7 index shift wrap", res_addr, 64'h2);
    endtask

    task automatic t_kind();
        issue(32'h20, 64'h100, 1'b1, 64'd0, 1'b0, 2'b00, 1'b1);
        check("R8 data kind", {62'd0, res_is_data, res_mem_req}, 64'd2);
        check("R8 data value", res_addr, 64'h120);
        issue(32'h20, 64'h100, 1'b1, 64'd0, 1'b0, 2'b00, 1'b0);
        check("R8 memory kind", {62'd0, res_is_data, res_mem_req}, 64'd1);
    endtask

    task automatic t_hold();
        issue(32'h77, 64'd0, 1'b0, 64'd0, 1'b0, 2'b00, 1'b1);
        req_disp = 32'h55; req_base_en = 1'b1; req_base = 64'h9999;
        @(negedge clk);
        check("R9 idle valid", {63'd0, res_valid}, 64'd0);
        check("R9 idle hold", res_addr, 64'h77);
        check("R8 idle kind", {62'd0, res_is_data, res_mem_req}, 64'd0);
    endtask

    task automatic t_ignore();
        issue(32'h44, 64'hDEAD_BEEF_0000_0000, 1'b0, 64'hCAFE_0000_0000_0000, 1'b0, 2'b11, 1'b0);
        check("R11 disabled terms", res_addr, 64'h44);
        issue(32'h4, 64'hDEAD_BEEF_0000_0000, 1'b0, 64'h10, 1'b1, 2'b10, 1'b0);
        check("R11 disabled base", res_addr, 64'h44);
    endtask

    initial begin
        t_reset();
        t_absolute();
        t_indirect();
        t_scaled();
        t_full();
        t_wrap();
        t_kind();
        t_hold();
        t_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule